// File: doc/BRIEF.md
# Eight-Bit Timer with Compare Output

The block is an 8-bit up-counter. It advances once for each prescaled count tick. A 3-bit waveform-mode field sets the counting sequence. In free-running mode the counter rolls over from its maximum value to zero. In clear-on-compare mode the counter returns to zero on the tick after it equals the compare register, so the compare register acts as the period. A separate 2-bit pin-action field decides what one output pin does on each compare match: toggle, force low, force high, or nothing. This field never changes the counting sequence.

Two sticky flags record events. The overflow flag records a rollover from the maximum value to zero. The compare flag records a compare match. Each flag also serves as the interrupt request line for its event. Each flag is cleared by an interrupt-acknowledge strobe or by a write-one-to-clear strobe from software. The counter, the compare value and both mode fields are loaded through write strobes. A counter write may arrive in any cycle.

Top module: `tmr8_unit`

## Requirements
- R1: After a synchronous reset, the counter and compare register read 0, both flags read 0, the pin reads 0, and both mode fields are 0.
- R2: When the waveform-mode field holds any value other than 2 (value 0 is the documented free-running setting), each tick adds one to the counter, 0xFF goes to 0x00, and a cycle without a tick holds the value.
- R3: The overflow flag is set at the same clock edge where a tick moves the counter from 0xFF to 0x00.
- R4: Hardware only sets the overflow flag. `ovf_ack` or `ovf_clr` clears it. If a set and a clear happen in the same cycle, the flag ends up set.
- R5: With the waveform-mode field at 2, a tick taken while the counter equals the compare register loads 0 instead of incrementing.
- R6: A tick taken while the counter equals the compare register sets the compare flag in any waveform mode. `cmp_ack` or `cmp_clr` clears the flag, and a set in the same cycle wins over a clear.
- R7: On a compare match the pin-action field acts on the pin: 1 toggles it, 2 drives it to 0, 3 drives it to 1, and 0 leaves it unchanged. The pin changes only at a compare match.
- R8: The pin-action field has no effect on the counter sequence in either waveform mode.
- R9: A counter write in the same cycle as a tick takes priority: the counter loads the written value, and neither a compare match nor an overflow is recorded for that cycle.
- R10: With the waveform-mode field at 2 and a compare value of 0, the counter stays at 0, every tick is a compare match, and with pin action 1 the pin toggles on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Value to load into the counter |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | 8 | Compare value |
| mode_wr | input | 1 | Loads both mode fields |
| wave_mode | input | 3 | Waveform mode (2 = clear on compare) |
| pin_mode | input | 2 | Pin action on compare match |
| ovf_ack | input | 1 | Interrupt acknowledge for overflow |
| ovf_clr | input | 1 | Software write-one-to-clear for overflow |
| cmp_ack | input | 1 | Interrupt acknowledge for compare |
| cmp_clr | input | 1 | Software write-one-to-clear for compare |
| cnt_q | output | 8 | Current counter value |
| cmp_q | output | 8 | Current compare value |
| pin_out | output | 1 | Compare output pin |
| ovf_flag | output | 1 | Overflow flag / interrupt request |
| cmp_flag | output | 1 | Compare flag / interrupt request |

## Verification
Embedded assertions check the following on every cycle:
- the counter holds its value when there is no tick;
- a counter write takes priority over a tick;
- a rollover clears the counter and sets the overflow flag;
- in clear-on-compare mode a match clears the counter;
- a flag set always wins over a clear;
- the pin moves only on a match.

The directed scenarios are needed to show the behaviours that depend on a history of register writes:
- the whole count sequence for each pin-action value;
- a match that a counter write suppresses;
- every pin action in turn;
- the degenerate compare value of zero.

// File: rtl/tmr8_pkg.sv
// Shared types and constants for the eight-bit timer.
// Assumes: pin-action and waveform codes are fixed by the register layout.
package tmr8_pkg;
    localparam int WAVE_W = 3;
    localparam logic [WAVE_W-1:0] WAVE_CTC = 3'd2;

    typedef enum logic [1:0] {
        PIN_OFF = 2'd0,
        PIN_TOG = 2'd1,
        PIN_CLR = 2'd2,
        PIN_SET = 2'd3
    } pin_act_e;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_OVF  = 0;
    localparam int FLAG_CMP  = 1;
endpackage

// File: rtl/tmr8_count.sv
// Counter core: loads, increments on tick, wraps at all-ones, clears on
// compare in clear-on-compare mode, and reports match and wrap events.
// Assumes: load has priority over tick and masks both events that cycle.
module tmr8_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctc_en,
    input  logic [CNT_W-1:0] top_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             match_ev,
    output logic             wrap_ev
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             step;
    logic             hit;
    logic [CNT_W-1:0] count_nxt;

    // Event decode: a step is a tick not overridden by a load.
    always_comb begin
        step     = tick & ~load;
        hit      = (count == top_val);
        match_ev = step & hit;
        wrap_ev  = step & (count == CNT_MAX);
    end

    // Next-value selection: load, then compare clear, then increment.
    always_comb begin
        if (load)
            count_nxt = load_val;
        else if (step && ctc_en && hit)
            count_nxt = '0;
        else if (step)
            count_nxt = count + 1'b1;
        else
            count_nxt = count;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else
            count <= count_nxt;
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_ev |=> (count == '0));
    p_ctc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctc_en && match_ev) |=> (count == '0));
    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
    p_zero_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctc_en && top_val == '0 && count == '0 && tick && !load)
        |=> (count == '0));
endmodule

// File: rtl/tmr8_pin.sv
// Compare output unit: applies the selected action to the pin on a match.
// Assumes: the action is sampled in the same cycle as the match event.
module tmr8_pin
    import tmr8_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     match_ev,
    input  pin_act_e act,
    output logic     pin
);
    // Pin register: updated only on a compare match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin <= 1'b0;
        else if (match_ev) begin
            case (act)
                PIN_TOG: pin <= ~pin;
                PIN_CLR: pin <= 1'b0;
                PIN_SET: pin <= 1'b1;
                default: pin <= pin;
            endcase
        end
    end

    p_pin_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !match_ev |=> $stable(pin));
    p_pin_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_ev && act == PIN_SET) |=> pin);
    p_pin_tog_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_ev && act == PIN_TOG) |=> (pin != $past(pin)));
endmodule

// File: rtl/tmr8_flag.sv
// Sticky event flag: set by hardware, cleared by a strobe, set wins.
// Assumes: clear strobes are single-cycle and already OR-ed together.
module tmr8_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr,
    output logic flag
);
    // Flag register with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_ev)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // Shared by both flags: R4 for overflow, R6 for compare.
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> flag);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_ev && clr) |=> !flag);
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_ev && !clr) |=> $stable(flag));
endmodule

// File: rtl/tmr8_unit.sv
// Eight-bit timer top: holds the compare and mode registers and connects
// the counter core, the compare output unit and the two event flags.
// Assumes: all write and clear strobes are synchronous to clk.
module tmr8_unit
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              cmp_wr,
    input  logic [CNT_W-1:0]  cmp_wdata,
    input  logic              mode_wr,
    input  logic [WAVE_W-1:0] wave_mode,
    input  logic [1:0]        pin_mode,
    input  logic              ovf_ack,
    input  logic              ovf_clr,
    input  logic              cmp_ack,
    input  logic              cmp_clr,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              pin_out,
    output logic              ovf_flag,
    output logic              cmp_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0]  cmp_r;
    logic [WAVE_W-1:0] wave_r;
    pin_act_e          act_r;
    logic              ctc_en;
    logic              match_ev;
    logic              wrap_ev;
    logic [NUM_FLAGS-1:0] set_v;
    logic [NUM_FLAGS-1:0] clr_v;
    logic [NUM_FLAGS-1:0] flag_v;

    // Control registers: compare value and both mode fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_r  <= '0;
            wave_r <= '0;
            act_r  <= PIN_OFF;
        end else begin
            if (cmp_wr)
                cmp_r <= cmp_wdata;
            if (mode_wr) begin
                wave_r <= wave_mode;
                act_r  <= pin_act_e'(pin_mode);
            end
        end
    end

    // Mode decode: only the waveform field steers the sequence.
    always_comb ctc_en = (wave_r == WAVE_CTC);

    tmr8_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctc_en   (ctc_en),
        .top_val  (cmp_r),
        .load     (cnt_wr),
        .load_val (cnt_wdata),
        .count    (cnt_q),
        .match_ev (match_ev),
        .wrap_ev  (wrap_ev)
    );

    tmr8_pin u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .match_ev (match_ev),
        .act      (act_r),
        .pin      (pin_out)
    );

    // Flag event and clear routing.
    always_comb begin
        set_v[FLAG_OVF] = wrap_ev;
        set_v[FLAG_CMP] = match_ev;
        clr_v[FLAG_OVF] = ovf_ack | ovf_clr;
        clr_v[FLAG_CMP] = cmp_ack | cmp_clr;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        tmr8_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_ev (set_v[g]),
            .clr    (clr_v[g]),
            .flag   (flag_v[g])
        );
    end

    always_comb begin
        ovf_flag = flag_v[FLAG_OVF];
        cmp_flag = flag_v[FLAG_CMP];
        cmp_q    = cmp_r;
    end

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt_q == CNT_MAX) |=> ovf_flag);
    p_cmp_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt_q == cmp_q) |=> cmp_flag);
    p_no_event_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !ovf_flag && !cmp_flag) |=> (!ovf_flag && !cmp_flag));
endmodule

// File: tb/test_tmr8_unit.sv
module test_tmr8_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = '0;
    logic       mode_wr = 1'b0;
    logic [2:0] wave_mode = '0;
    logic [1:0] pin_mode = '0;
    logic       ovf_ack = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       cmp_ack = 1'b0;
    logic       cmp_clr = 1'b0;
    logic [7:0] cnt_q;
    logic [7:0] cmp_q;
    logic       pin_out;
    logic       ovf_flag;
    logic       cmp_flag;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    tmr8_unit i_tmr8_unit (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .mode_wr(mode_wr), .wave_mode(wave_mode), .pin_mode(pin_mode),
        .ovf_ack(ovf_ack), .ovf_clr(ovf_clr),
        .cmp_ack(cmp_ack), .cmp_clr(cmp_clr),
        .cnt_q(cnt_q), .cmp_q(cmp_q), .pin_out(pin_out),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) cyc();
        tick = 1'b0;
    endtask

    task automatic write_cnt(input logic [7:0] v);
        cnt_wr = 1'b1; cnt_wdata = v;
        cyc();
        cnt_wr = 1'b0;
    endtask

    task automatic write_cmp(input logic [7:0] v);
        cmp_wr = 1'b1; cmp_wdata = v;
        cyc();
        cmp_wr = 1'b0;
    endtask

    task automatic write_mode(input logic [2:0] w, input logic [1:0] p);
        mode_wr = 1'b1; wave_mode = w; pin_mode = p;
        cyc();
        mode_wr = 1'b0;
    endtask

    task automatic clear_flags();
        ovf_clr = 1'b1; cmp_clr = 1'b1;
        cyc();
        ovf_clr = 1'b0; cmp_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cnt", cnt_q, 0);
        chk("R1 cmp", cmp_q, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 cmpf", cmp_flag, 0);
        chk("R1 pin", pin_out, 0);
    endtask

    task automatic t_normal();
        write_cnt(8'hFD);
        ticks(1);
        chk("R2 inc", cnt_q, 8'hFE);
        cyc();
        chk("R2 hold", cnt_q, 8'hFE);
        ticks(1);
        chk("R2 to max", cnt_q, 8'hFF);
        chk("R3 no ovf yet", ovf_flag, 0);
        ticks(1);
        chk("R2 wrap", cnt_q, 8'h00);
        chk("R3 ovf at wrap", ovf_flag, 1);
        // Waveform value 5 must count like normal mode.
        write_cmp(8'd3);
        write_mode(3'd5, 2'd0);
        write_cnt(8'd3);
        clear_flags();
        ticks(1);
        chk("R2 mode5 no clear", cnt_q, 8'd4);
        chk("R6 match mode5", cmp_flag, 1);
    endtask

    task automatic t_ovf_flag();
        write_mode(3'd0, 2'd0);
        clear_flags();
        write_cnt(8'hFF);
        ticks(1);
        chk("R4 set", ovf_flag, 1);
        ticks(2);
        chk("R4 sticky", ovf_flag, 1);
        ovf_ack = 1'b1; cyc(); ovf_ack = 1'b0;
        chk("R4 ack clears", ovf_flag, 0);
        write_cnt(8'hFF);
        ovf_clr = 1'b1; tick = 1'b1;
        cyc();
        ovf_clr = 1'b0; tick = 1'b0;
        chk("R4 set wins", ovf_flag, 1);
        ovf_clr = 1'b1; cyc(); ovf_clr = 1'b0;
        chk("R4 w1c clears", ovf_flag, 0);
    endtask

    task automatic t_ctc();
        write_mode(3'd2, 2'd0);
        write_cmp(8'd4);
        write_cnt(8'd0);
        clear_flags();
        ticks(4);
        chk("R5 reach top", cnt_q, 8'd4);
        chk("R6 no early match", cmp_flag, 0);
        ticks(1);
        chk("R5 clear", cnt_q, 8'd0);
        chk("R6 match", cmp_flag, 1);
        cmp_ack = 1'b1; cyc(); cmp_ack = 1'b0;
        chk("R6 ack clears", cmp_flag, 0);
        ticks(4);
        cmp_clr = 1'b1; tick = 1'b1;
        cyc();
        cmp_clr = 1'b0; tick = 1'b0;
        chk("R5 clear again", cnt_q, 8'd0);
        chk("R6 set wins", cmp_flag, 1);
    endtask

    task automatic t_pin();
        write_mode(3'd2, 2'd1);
        write_cmp(8'd2);
        write_cnt(8'd0);
        chk("R7 pin start", pin_out, 0);
        ticks(2);
        chk("R7 no move before match", pin_out, 0);
        ticks(1);
        chk("R7 toggle up", pin_out, 1);
        ticks(3);
        chk("R7 toggle down", pin_out, 0);
        write_mode(3'd2, 2'd3);
        ticks(3);
        chk("R7 set", pin_out, 1);
        ticks(3);
        chk("R7 set again", pin_out, 1);
        write_mode(3'd2, 2'd2);
        ticks(3);
        chk("R7 clear", pin_out, 0);
        write_mode(3'd2, 2'd3);
        ticks(3);
        write_mode(3'd2, 2'd0);
        clear_flags();
        ticks(3);
        chk("R7 off holds", pin_out, 1);
        chk("R6 match while off", cmp_flag, 1);
    endtask

    task automatic t_seq_indep();
        for (int p = 0; p < 4; p++) begin
            write_mode(3'd2, p[1:0]);
            write_cmp(8'd3);
            write_cnt(8'd0);
            ticks(3);
            chk("R8 ctc top", cnt_q, 8'd3);
            ticks(1);
            chk("R8 ctc clear", cnt_q, 8'd0);
            write_mode(3'd0, p[1:0]);
            write_cnt(8'd10);
            ticks(5);
            chk("R8 normal", cnt_q, 8'd15);
        end
    endtask

    task automatic t_wr_prio();
        write_mode(3'd0, 2'd0);
        write_cmp(8'd20);
        write_cnt(8'd19);
        cnt_wr = 1'b1; cnt_wdata = 8'd50; tick = 1'b1;
        cyc();
        cnt_wr = 1'b0; tick = 1'b0;
        chk("R9 write wins", cnt_q, 8'd50);
        write_cnt(8'd20);
        clear_flags();
        cnt_wr = 1'b1; cnt_wdata = 8'd7; tick = 1'b1;
        cyc();
        cnt_wr = 1'b0; tick = 1'b0;
        chk("R9 loaded", cnt_q, 8'd7);
        chk("R9 match masked", cmp_flag, 0);
        write_cnt(8'hFF);
        clear_flags();
        cnt_wr = 1'b1; cnt_wdata = 8'h80; tick = 1'b1;
        cyc();
        cnt_wr = 1'b0; tick = 1'b0;
        chk("R9 loaded over wrap", cnt_q, 8'h80);
        chk("R9 ovf masked", ovf_flag, 0);
    endtask

    task automatic t_cmp_zero();
        logic p0;
        write_mode(3'd2, 2'd1);
        write_cmp(8'd0);
        write_cnt(8'd0);
        clear_flags();
        p0 = pin_out;
        for (int i = 1; i <= 4; i++) begin
            ticks(1);
            chk("R10 stays zero", cnt_q, 8'd0);
            chk("R10 toggles", pin_out, p0 ^ i[0]);
            chk("R10 match", cmp_flag, 1);
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_normal();
        t_ovf_flag();
        t_ctc();
        t_pin();
        t_seq_indep();
        t_wr_prio();
        t_cmp_zero();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule